// File: doc/BRIEF.md
# Debug Suspend Routing Controller

This block lets a debugger freeze peripherals, such as timers, in step with the processor core they serve. Each controllable peripheral owns one 32-bit control word. The word holds a five-bit initiator selector and an enable gate. While the gate is set, the peripheral's suspend request follows the debug-halted flag of the selected initiator. The peripheral stops when that core is halted and runs again when the core resumes, with no software in the loop.

The control words can be reached through two independent register ports: one on the system bus and one on the debug configuration bus. Both ports read and write the same storage. Each port has a one-cycle read latency and returns an error pulse for any access outside the peripheral count. The suspend outputs are registered.

Top module: `dsr_router`

## Requirements
- R1: While reset is high, and on the first cycle after it, every control word is zero, every suspend output is low, both read-data buses are zero and both error flags are low.
- R2: A write stores data bit 16 as the enable gate and data bits 4:0 as the initiator selector. A read issued in cycle t presents the word on that port's read data after the next clock edge; read data is zero in cycles that follow no read.
- R3: Reserved bits (31:17 and 15:5) ignore writes and always read as zero.
- R4: With the gate set, suspend output p equals the halted flag of the selected initiator, registered, so it changes one clock after the flag or the control word changes.
- R5: With the gate clear, suspend output p stays low whatever the selector and the halted flags hold.
- R6: Both ports access the same storage; a word written through one port reads back through the other.
- R7: When both ports write the same word in the same cycle, the debug-port data is stored.
- R8: An access to an index at or above the peripheral count reads zero, changes no word, and raises the error flag of the issuing port for one cycle after the access; in-range accesses raise no error.
- R9: A read and a write to the same word in the same cycle return the value held before the write.
- R10: Writes from the two ports to different words in the same cycle both take effect.
- R11: A selector at or above the initiator count never suspends its peripheral, even with the gate set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halted_i | input | NUM_INIT | Debug-halted flag per initiator |
| suspend_o | output | NUM_PERIPH | Registered suspend request per peripheral |
| sys_re | input | 1 | System port read strobe |
| sys_we | input | 1 | System port write strobe |
| sys_addr | input | AW | System port word index |
| sys_wdata | input | 32 | System port write data |
| sys_rdata | output | 32 | System port read data, one cycle after the read |
| sys_err | output | 1 | System port out-of-range error pulse |
| dbg_re | input | 1 | Debug port read strobe |
| dbg_we | input | 1 | Debug port write strobe |
| dbg_addr | input | AW | Debug port word index |
| dbg_wdata | input | 32 | Debug port write data |
| dbg_rdata | output | 32 | Debug port read data, one cycle after the read |
| dbg_err | output | 1 | Debug port out-of-range error pulse |

## Verification
The routing is exercised with the selected core's flag toggled alone and with other cores' flags toggled alone. This shows whether the selector picks the right bit rather than any set bit. The same patterns are repeated with the gate cleared and with a selector beyond the initiator count, which separates a gated path from one that leaks. The register side is tried with all-ones data, which exposes reserved-bit storage, and with cross-port writes and reads. Colliding writes, same-cycle read-and-write, and out-of-range indices show the priority, the read timing and the address decode.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int SEL_W  = 5;
  localparam int EN_BIT = 16;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  function automatic logic [31:0] ctl_to_word(ctl_t c);
    logic [31:0] w;
    w = '0;
    w[EN_BIT] = c.en;
    w[SEL_W-1:0] = c.sel;
    return w;
  endfunction

  function automatic ctl_t word_to_ctl(logic [31:0] w);
    ctl_t c;
    c.en  = w[EN_BIT];
    c.sel = w[SEL_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/dsr_regfile.sv
module dsr_regfile
  import dsr_pkg::*;
#(
  parameter int NUM_PERIPH = 12,
  parameter int AW         = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sys_we,
  input  logic [AW-1:0]          sys_addr,
  input  logic [31:0]            sys_wdata,
  input  logic                   dbg_we,
  input  logic [AW-1:0]          dbg_addr,
  input  logic [31:0]            dbg_wdata,
  output ctl_t [NUM_PERIPH-1:0]  ctl_q
);
  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_word
    logic sys_hit, dbg_hit;
    assign sys_hit = sys_we && (sys_addr == AW'(i));
    assign dbg_hit = dbg_we && (dbg_addr == AW'(i));

    always_ff @(posedge clk) begin
      if (rst)          ctl_q[i] <= '0;
      else if (dbg_hit) ctl_q[i] <= word_to_ctl(dbg_wdata);
      else if (sys_hit) ctl_q[i] <= word_to_ctl(sys_wdata);
    end
  end
endmodule

// File: rtl/dsr_rd_port.sv
module dsr_rd_port
  import dsr_pkg::*;
#(
  parameter int NUM_PERIPH = 12,
  parameter int AW         = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  re,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  ctl_t [NUM_PERIPH-1:0] ctl_q,
  output logic [31:0]           rdata,
  output logic                  err
);
  localparam int IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

  logic in_range;
  ctl_t picked;

  assign in_range = ({1'b0, addr} < (AW+1)'(NUM_PERIPH));

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_PERIPH; i++)
      if (addr == AW'(i)) picked = ctl_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= (re && in_range) ? ctl_to_word(picked) : '0;
      err   <= (re || we) && !in_range;
    end
  end

  logic [IDX_W-1:0] unused_idx;
  assign unused_idx = '0;
endmodule

// File: rtl/dsr_route.sv
module dsr_route
  import dsr_pkg::*;
#(
  parameter int NUM_PERIPH = 12,
  parameter int NUM_INIT   = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_INIT-1:0]   halted_i,
  input  ctl_t [NUM_PERIPH-1:0] ctl_q,
  output logic [NUM_PERIPH-1:0] suspend_o
);
  localparam int SEL_SPAN = 1 << SEL_W;

  logic [SEL_SPAN-1:0] halt_ext;
  assign halt_ext = SEL_SPAN'(halted_i);

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst) suspend_o[p] <= 1'b0;
      else     suspend_o[p] <= ctl_q[p].en && halt_ext[ctl_q[p].sel];
    end
  end
endmodule

// File: rtl/dsr_router.sv
module dsr_router
  import dsr_pkg::*;
#(
  parameter int NUM_PERIPH = 12,
  parameter int NUM_INIT   = 20,
  parameter int AW         = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_INIT-1:0]   halted_i,
  output logic [NUM_PERIPH-1:0] suspend_o,
  input  logic                  sys_re,
  input  logic                  sys_we,
  input  logic [AW-1:0]         sys_addr,
  input  logic [31:0]           sys_wdata,
  output logic [31:0]           sys_rdata,
  output logic                  sys_err,
  input  logic                  dbg_re,
  input  logic                  dbg_we,
  input  logic [AW-1:0]         dbg_addr,
  input  logic [31:0]           dbg_wdata,
  output logic [31:0]           dbg_rdata,
  output logic                  dbg_err
);
  ctl_t [NUM_PERIPH-1:0]            ctl_q;
  logic [NUM_PERIPH-1:0]            en_q;
  logic [NUM_PERIPH-1:0][SEL_W-1:0] sel_q;

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_view
    assign en_q[p]  = ctl_q[p].en;
    assign sel_q[p] = ctl_q[p].sel;
  end

  dsr_regfile #(.NUM_PERIPH(NUM_PERIPH), .AW(AW)) u_regs (
    .clk(clk), .rst(rst),
    .sys_we(sys_we), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .ctl_q(ctl_q)
  );

  dsr_rd_port #(.NUM_PERIPH(NUM_PERIPH), .AW(AW)) u_sys_rd (
    .clk(clk), .rst(rst), .re(sys_re), .we(sys_we), .addr(sys_addr),
    .ctl_q(ctl_q), .rdata(sys_rdata), .err(sys_err)
  );

  dsr_rd_port #(.NUM_PERIPH(NUM_PERIPH), .AW(AW)) u_dbg_rd (
    .clk(clk), .rst(rst), .re(dbg_re), .we(dbg_we), .addr(dbg_addr),
    .ctl_q(ctl_q), .rdata(dbg_rdata), .err(dbg_err)
  );

  dsr_route #(.NUM_PERIPH(NUM_PERIPH), .NUM_INIT(NUM_INIT)) u_route (
    .clk(clk), .rst(rst), .halted_i(halted_i), .ctl_q(ctl_q),
    .suspend_o(suspend_o)
  );
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int NUM_PERIPH = 12,
  parameter int NUM_INIT   = 20,
  parameter int AW         = 6
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_INIT-1:0]         halted_i,
  input logic [NUM_PERIPH-1:0]       suspend_o,
  input logic                        sys_re,
  input logic                        sys_we,
  input logic [AW-1:0]               sys_addr,
  input logic [31:0]                 sys_rdata,
  input logic                        sys_err,
  input logic                        dbg_we,
  input logic [AW-1:0]               dbg_addr,
  input logic [31:0]                 dbg_wdata,
  input logic [31:0]                 dbg_rdata,
  input logic [NUM_PERIPH-1:0]       en_q,
  input logic [NUM_PERIPH-1:0][4:0]  sel_q
);
  logic [31:0] halt_ext;
  logic        rst_d;
  assign halt_ext = 32'(halted_i);

  always_ff @(posedge clk) rst_d <= rst;

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (suspend_o == '0) && !sys_err && (sys_rdata == '0));

  // R3
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (sys_rdata[31:17] == '0) && (sys_rdata[15:5] == '0) &&
    (dbg_rdata[31:17] == '0) && (dbg_rdata[15:5] == '0));

  // R8
  p_err_range_r8: assert property (@(posedge clk) disable iff (rst)
    ((sys_re || sys_we) && ({1'b0, sys_addr} >= (AW+1)'(NUM_PERIPH))) |=> sys_err);
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !((sys_re || sys_we) && ({1'b0, sys_addr} >= (AW+1)'(NUM_PERIPH))) |=> !sys_err);

  // R7
  p_dbg_wins_r7: assert property (@(posedge clk) disable iff (rst || rst_d)
    (dbg_we && sys_we && (dbg_addr == sys_addr) &&
     ({1'b0, dbg_addr} < (AW+1)'(NUM_PERIPH)))
    |=> (sel_q[$past(dbg_addr)] == $past(dbg_wdata[4:0])));

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_chk
    // R5
    p_gate_off_r5: assert property (@(posedge clk) disable iff (rst || rst_d)
      !$past(en_q[p]) |-> !suspend_o[p]);
    // R4 and R11
    p_follow_r4: assert property (@(posedge clk) disable iff (rst || rst_d)
      $past(en_q[p]) |->
        suspend_o[p] == ($past(sel_q[p]) < 5'(NUM_INIT) && $past(halt_ext[sel_q[p]])));
  end
endmodule

bind dsr_router dsr_checker #(.NUM_PERIPH(NUM_PERIPH), .NUM_INIT(NUM_INIT), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .halted_i(halted_i), .suspend_o(suspend_o),
  .sys_re(sys_re), .sys_we(sys_we), .sys_addr(sys_addr),
  .sys_rdata(sys_rdata), .sys_err(sys_err),
  .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
  .dbg_rdata(dbg_rdata), .en_q(en_q), .sel_q(sel_q)
);

// File: tb/dsr_router_bench.sv
module dsr_router_bench;
  localparam int NP = 12;
  localparam int NI = 20;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0] halted_i = '0;
  logic [NP-1:0] suspend_o;
  logic sys_re = 0, sys_we = 0, dbg_re = 0, dbg_we = 0;
  logic [AW-1:0] sys_addr = '0, dbg_addr = '0;
  logic [31:0] sys_wdata = '0, dbg_wdata = '0;
  logic [31:0] sys_rdata, dbg_rdata;
  logic sys_err, dbg_err;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  dsr_router #(.NUM_PERIPH(NP), .NUM_INIT(NI), .AW(AW)) u_dsr_router (.*);

  // behavioural reference model
  logic [31:0] mreg [NP];
  logic [NP-1:0] exp_susp = '0;
  logic [31:0] exp_srd = '0, exp_drd = '0;
  logic exp_serr = 0, exp_derr = 0;

  function automatic logic mhalt(logic [31:0] w, logic [NI-1:0] h);
    int s = int'(w[4:0]);
    return w[16] && (s < NI) && h[s];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (mreg[i]) mreg[i] = '0;
      exp_susp = '0; exp_srd = '0; exp_drd = '0; exp_serr = 0; exp_derr = 0;
    end else begin
      for (int p = 0; p < NP; p++) exp_susp[p] = mhalt(mreg[p], halted_i);
      exp_srd  = (sys_re && int'(sys_addr) < NP) ? mreg[sys_addr] : '0;
      exp_drd  = (dbg_re && int'(dbg_addr) < NP) ? mreg[dbg_addr] : '0;
      exp_serr = (sys_re || sys_we) && int'(sys_addr) >= NP;
      exp_derr = (dbg_re || dbg_we) && int'(dbg_addr) >= NP;
      if (sys_we && int'(sys_addr) < NP) mreg[sys_addr] = sys_wdata & 32'h0001_001F;
      if (dbg_we && int'(dbg_addr) < NP) mreg[dbg_addr] = dbg_wdata & 32'h0001_001F;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R4 suspend vs model", 32'(suspend_o), 32'(exp_susp));
    chk("R2 sys_rdata vs model", sys_rdata, exp_srd);
    chk("R2 dbg_rdata vs model", dbg_rdata, exp_drd);
    chk("R8 err vs model", {30'b0, sys_err, dbg_err}, {30'b0, exp_serr, exp_derr});
  end

  task automatic sys_wr(int a, logic [31:0] d);
    @(negedge clk); sys_we = 1; sys_addr = AW'(a); sys_wdata = d;
    @(negedge clk); sys_we = 0;
  endtask
  task automatic dbg_wr(int a, logic [31:0] d);
    @(negedge clk); dbg_we = 1; dbg_addr = AW'(a); dbg_wdata = d;
    @(negedge clk); dbg_we = 0;
  endtask
  task automatic sys_rd(int a, output logic [31:0] v);
    @(negedge clk); sys_re = 1; sys_addr = AW'(a);
    @(negedge clk); sys_re = 0; v = sys_rdata;
  endtask
  task automatic dbg_rd(int a, output logic [31:0] v);
    @(negedge clk); dbg_re = 1; dbg_addr = AW'(a);
    @(negedge clk); dbg_re = 0; v = dbg_rdata;
  endtask
  task automatic set_halt(logic [NI-1:0] h);
    @(negedge clk); halted_i = h;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    chk("R1 reset suspend", 32'(suspend_o), 0);
    chk("R1 reset rdata", sys_rdata | dbg_rdata, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 first cycle after reset", 32'(suspend_o), 0);
    for (int i = 0; i < NP; i++) begin
      sys_rd(i, v); chk("R1 word zero after reset", v, 0);
    end

    // R2 and R3
    sys_wr(2, 32'h0001_0003);
    sys_rd(2, v); chk("R2 readback", v, 32'h0001_0003);
    sys_wr(4, 32'hFFFF_FFFF);
    sys_rd(4, v); chk("R3 reserved bits zero", v, 32'h0001_001F);

    // R4: peripheral 2 follows initiator 3 only
    set_halt(20'h0_0004);
    @(negedge clk); chk("R4 other core halted", 32'(suspend_o[2]), 0);
    set_halt(20'h0_0008);
    @(negedge clk); chk("R4 selected core halted", 32'(suspend_o[2]), 1);
    set_halt(20'h0_0000);
    @(negedge clk); chk("R4 selected core resumed", 32'(suspend_o[2]), 0);

    // R5: gate clear
    sys_wr(2, 32'h0000_0003);
    set_halt('1);
    @(negedge clk); chk("R5 gate clear no suspend", 32'(suspend_o[2]), 0);
    set_halt('0);

    // R11: selector 31 beyond initiator count (peripheral 4, gate set)
    set_halt('1);
    @(negedge clk); chk("R11 selector beyond count", 32'(suspend_o[4]), 0);
    set_halt('0);

    // R6: cross-port visibility
    sys_wr(5, 32'h0001_000A);
    dbg_rd(5, v); chk("R6 sys write dbg read", v, 32'h0001_000A);
    dbg_wr(6, 32'h0001_0013);
    sys_rd(6, v); chk("R6 dbg write sys read", v, 32'h0001_0013);

    // R7: collision
    @(negedge clk); sys_we = 1; dbg_we = 1; sys_addr = 7; dbg_addr = 7;
    sys_wdata = 32'h0001_0001; dbg_wdata = 32'h0001_0002;
    @(negedge clk); sys_we = 0; dbg_we = 0;
    sys_rd(7, v); chk("R7 debug port wins", v, 32'h0001_0002);

    // R10: simultaneous writes to different words
    @(negedge clk); sys_we = 1; dbg_we = 1; sys_addr = 8; dbg_addr = 9;
    sys_wdata = 32'h0001_0004; dbg_wdata = 32'h0000_0005;
    @(negedge clk); sys_we = 0; dbg_we = 0;
    sys_rd(8, v); chk("R10 sys word", v, 32'h0001_0004);
    dbg_rd(9, v); chk("R10 dbg word", v, 32'h0000_0005);

    // R9: read and write same word same cycle
    @(negedge clk); sys_re = 1; sys_we = 1; sys_addr = 8; sys_wdata = 32'h0001_000C;
    @(negedge clk); sys_re = 0; sys_we = 0;
    chk("R9 old value returned", sys_rdata, 32'h0001_0004);
    sys_rd(8, v); chk("R9 new value stored", v, 32'h0001_000C);

    // R8: out of range
    @(negedge clk); dbg_we = 1; dbg_addr = AW'(NP); dbg_wdata = 32'h0001_0000;
    @(negedge clk); dbg_we = 0;
    chk("R8 debug error pulse", 32'(dbg_err), 1);
    @(negedge clk); chk("R8 error one cycle", 32'(dbg_err), 0);
    sys_rd(63, v); chk("R8 reads zero", v, 0);
    chk("R8 sys error pulse", 32'(sys_err), 1);
    for (int i = 0; i < NP; i++) begin
      dbg_rd(i, v); chk("R8 no word changed", v, mreg[i]);
    end

    // main function sweep: walking halt across all initiators
    for (int p = 0; p < NP; p++) dbg_wr(p, 32'h0001_0000 | 32'((p * 3) % NI));
    for (int k = 0; k < NI; k++) begin
      set_halt(NI'(1) << k);
      @(negedge clk);
      for (int p = 0; p < NP; p++)
        chk("R4 walking halt", 32'(suspend_o[p]), 32'(((p * 3) % NI) == k));
    end
    set_halt('0);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule